// File: doc/BRIEF.md
# Product-Term Logic Macrocell

This block is one configurable cell of a small programmable logic fabric used for supply sequencing and control. Five AND terms, already formed upstream, are ORed together. A polarity bit can invert the result through an XOR. The outcome then either drives the output directly (combinational bypass) or is stored in a flip-flop. The flip-flop acts as a D or a T element, chosen per cell.

The storage element advances only on a slow logic clock, obtained by dividing the master clock by 32. The divider is built as a one-cycle enable pulse on the master clock, so the block runs in a single clock domain. The block also contains the two input capture stages that feed the fabric. Digital inputs are captured on every master clock edge. Comparator inputs are captured only on logic-clock edges.

The flip-flop has an asynchronous clear and an asynchronous preset. Each one picks its source from a dedicated product term, the active-low global reset pin, or the active-low power-on reset. Either one can also be switched off. The power-on reset always clears the flip-flop, the divider and the capture stages. The global reset pin always restarts the divider.

Top module: `pt_macrocell`

## Requirements
- R1: In D mode (mode code 0), on each logic-clock edge the stored bit becomes the OR of the five product terms, XORed with the polarity bit (invert=1 inverts).
- R2: In T mode (mode code 1), on a logic-clock edge the stored bit toggles when the post-polarity value is 1 and holds when it is 0.
- R3: In bypass mode (mode code 2 or 3), the output equals the post-polarity value combinationally, with no clock edge needed.
- R4: The logic-clock enable is high for exactly one master cycle in every 32. After a reset is released, it is first seen after the 31st master edge. In D or T mode the output does not change between logic-clock edges.
- R5: The clear source select works as follows. Code 0 selects the clear product term (active high). Code 1 selects the global reset pin (active low). Code 2 selects power-on reset. Code 3 selects none. The selected source clears the stored bit at once, without a clock edge.
- R6: The preset source select uses the same codes. The selected source forces the stored bit to 1 at once.
- R7: When clear and preset are active together, the stored bit is 0.
- R8: Power-on reset (low) clears the stored bit, the divider and the capture stages. The global reset pin (low) restarts the divider regardless of the source selects.
- R9: Digital inputs appear at their outputs one master clock after they are driven. Comparator inputs are taken only on a logic-clock edge and hold in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| grst_ni | input | 1 | Global reset pin, active low |
| dig_i | input | N_DIG | Raw digital inputs |
| cmp_i | input | N_CMP | Raw comparator outputs |
| dig_o | output | N_DIG | Digital inputs captured on the master clock |
| cmp_o | output | N_CMP | Comparator inputs captured on the logic clock |
| pt_i | input | NUM_PT | Product terms feeding the OR gate |
| mode_i | input | 2 | 0 D, 1 T, 2 or 3 bypass |
| invert_i | input | 1 | Polarity invert of the OR result |
| rst_sel_i | input | 2 | Clear source select |
| set_sel_i | input | 2 | Preset source select |
| rst_pt_i | input | 1 | Clear product term, active high |
| set_pt_i | input | 1 | Preset product term, active high |
| tick_o | output | 1 | Logic-clock enable, one master cycle wide |
| q_o | output | 1 | Cell output |

## Verification
Asynchronous clear and preset can overlap with each other. They can also coincide with a pending logic-clock update. The bench drives both product-term sources high together and expects the stored bit to read 0 before any clock edge. It releases the preset first, so that no later edge raises the bit by surprise. In separate cases it holds new D and T inputs across the enable pulse and checks that the output keeps its old value right up to the consuming edge. The updates are compared through a scoreboard queue at the following sample point.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_D   = 2'd0,
    MODE_T   = 2'd1,
    MODE_BYP = 2'd2,
    MODE_BY2 = 2'd3
  } mc_mode_e;

  typedef enum logic [1:0] {
    SRC_PT  = 2'd0,
    SRC_GLB = 2'd1,
    SRC_POR = 2'd2,
    SRC_OFF = 2'd3
  } mc_src_e;
endpackage

// File: rtl/mc_clk_div.sv
module mc_clk_div #(
  parameter int DIV_RATIO = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grst_ni,
  output logic tick_o
);
  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             div_rst_n;

  assign div_rst_n = rst_ni & grst_ni;

  always_ff @(posedge clk_i or negedge div_rst_n) begin
    if (!div_rst_n)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  assert_tick_single_R4: assert property (@(posedge clk_i) disable iff (!div_rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/mc_input_stage.sv
module mc_input_stage #(
  parameter int N_DIG = 4,
  parameter int N_CMP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_DIG-1:0] dig_i,
  input  logic [N_CMP-1:0] cmp_i,
  output logic [N_DIG-1:0] dig_o,
  output logic [N_CMP-1:0] cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dig_o <= '0;
    else         dig_o <= dig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_o <= '0;
    else if (tick_i) cmp_o <= cmp_i;
  end

  assert_cmp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cmp_o));
endmodule

// File: rtl/mc_async_ctl.sv
module mc_async_ctl
  import mc_pkg::*;
(
  input  logic [1:0] rst_sel_i,
  input  logic [1:0] set_sel_i,
  input  logic       rst_pt_i,
  input  logic       set_pt_i,
  input  logic       grst_ni,
  input  logic       por_ni,
  output logic       clr_o,
  output logic       set_o
);
  function automatic logic pick(input logic [1:0] sel, input logic pt,
                                input logic glb_n, input logic por_n);
    case (mc_src_e'(sel))
      SRC_PT:  pick = pt;
      SRC_GLB: pick = ~glb_n;
      SRC_POR: pick = ~por_n;
      default: pick = 1'b0;
    endcase
  endfunction

  // power-on reset always clears, on top of the selected source
  assign clr_o = ~por_ni | pick(rst_sel_i, rst_pt_i, grst_ni, por_ni);
  assign set_o = pick(set_sel_i, set_pt_i, grst_ni, por_ni);
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_PT = 5
) (
  input  logic              clk_i,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [1:0]        mode_i,
  input  logic              invert_i,
  output logic              pol_o,
  output logic              reg_o
);
  logic or_term;
  logic q_q;

  assign or_term = |pt_i;
  assign pol_o   = or_term ^ invert_i;

  // clear outranks preset
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)       q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (tick_i) begin
      case (mc_mode_e'(mode_i))
        MODE_D:  q_q <= pol_o;
        MODE_T:  q_q <= q_q ^ pol_o;
        default: q_q <= q_q;
      endcase
    end
  end

  assign reg_o = q_q;
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_PT    = 5,
  parameter int DIV_RATIO = 32,
  parameter int N_DIG     = 4,
  parameter int N_CMP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grst_ni,
  input  logic [N_DIG-1:0]  dig_i,
  input  logic [N_CMP-1:0]  cmp_i,
  output logic [N_DIG-1:0]  dig_o,
  output logic [N_CMP-1:0]  cmp_o,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [1:0]        mode_i,
  input  logic              invert_i,
  input  logic [1:0]        rst_sel_i,
  input  logic [1:0]        set_sel_i,
  input  logic              rst_pt_i,
  input  logic              set_pt_i,
  output logic              tick_o,
  output logic              q_o
);
  logic tick, clr_a, set_a, pol, reg_q, bypass;

  mc_clk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .grst_ni(grst_ni), .tick_o(tick));

  mc_input_stage #(.N_DIG(N_DIG), .N_CMP(N_CMP)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .dig_i(dig_i), .cmp_i(cmp_i), .dig_o(dig_o), .cmp_o(cmp_o));

  mc_async_ctl u_actl (
    .rst_sel_i(rst_sel_i), .set_sel_i(set_sel_i),
    .rst_pt_i(rst_pt_i), .set_pt_i(set_pt_i),
    .grst_ni(grst_ni), .por_ni(rst_ni),
    .clr_o(clr_a), .set_o(set_a));

  mc_cell #(.NUM_PT(NUM_PT)) u_cell (
    .clk_i(clk_i), .tick_i(tick), .clr_i(clr_a), .set_i(set_a),
    .pt_i(pt_i), .mode_i(mode_i), .invert_i(invert_i),
    .pol_o(pol), .reg_o(reg_q));

  assign bypass = mode_i[1];
  assign q_o    = bypass ? pol : reg_q;
  assign tick_o = tick;

  assert_d_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && mode_i == MODE_D && !clr_a && !set_a) |=>
      (reg_q == $past(pol) || clr_a || set_a));

  assert_t_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && mode_i == MODE_T && !clr_a && !set_a) |=>
      (reg_q == ($past(reg_q) ^ $past(pol)) || clr_a || set_a));

  assert_preset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_a && !clr_a) |-> reg_q);

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_a |-> !reg_q);
endmodule

// File: tb/pt_macrocell_test.sv
module pt_macrocell_test;
  import mc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni, grst_ni;
  logic [3:0] dig_i, cmp_i, dig_o, cmp_o;
  logic [4:0] pt_i;
  logic [1:0] mode_i, rst_sel_i, set_sel_i;
  logic       invert_i, rst_pt_i, set_pt_i, tick_o, q_o;

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic  model_q = 1'b0;
  logic  tick_d = 1'b0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pt_macrocell uut (
    .clk_i(clk), .rst_ni(rst_ni), .grst_ni(grst_ni),
    .dig_i(dig_i), .cmp_i(cmp_i), .dig_o(dig_o), .cmp_o(cmp_o),
    .pt_i(pt_i), .mode_i(mode_i), .invert_i(invert_i),
    .rst_sel_i(rst_sel_i), .set_sel_i(set_sel_i),
    .rst_pt_i(rst_pt_i), .set_pt_i(set_pt_i),
    .tick_o(tick_o), .q_o(q_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: one sample after each consuming edge
  always @(negedge clk) begin
    if (tick_d && exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(q_o === e, t, int'(q_o), int'(e));
    end
    tick_d = tick_o;
  end

  task automatic step(input logic [4:0] pt, input logic [1:0] m,
                      input logic inv, input string req);
    logic pol, e;
    pt_i = pt; mode_i = m; invert_i = inv;
    pol = (|pt) ^ inv;
    e = (m == MODE_T) ? (model_q ^ pol) : pol;
    while (!tick_o) @(negedge clk);
    chk(q_o === model_q, "R4 hold", int'(q_o), int'(model_q));
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    @(negedge clk);
    model_q = e;
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o && n < 100);
  endtask

  initial begin
    int n;
    rst_ni = 1'b0; grst_ni = 1'b1;
    dig_i = '0; cmp_i = '0; pt_i = '0; mode_i = MODE_D; invert_i = 1'b0;
    rst_sel_i = SRC_OFF; set_sel_i = SRC_OFF; rst_pt_i = 1'b0; set_pt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_o === 1'b0, "R8 q reset", int'(q_o), 0);
    chk(tick_o === 1'b0, "R8 tick reset", int'(tick_o), 0);
    chk(dig_o === 4'h0 && cmp_o === 4'h0, "R8 capture reset", int'({dig_o, cmp_o}), 0);
    rst_ni = 1'b1;
    count_to_tick(n);
    chk(n == 31, "R4 first tick", n, 31);
    @(negedge clk);
    chk(tick_o === 1'b0, "R4 tick width", int'(tick_o), 0);
    n = 1;
    while (!tick_o && n < 100) begin @(negedge clk); n++; end
    chk(n == 32, "R4 tick period", n, 32);
    @(negedge clk);

    // R1 D mode patterns
    step(5'b00000, MODE_D, 1'b0, "R1 zero");
    step(5'b00100, MODE_D, 1'b0, "R1 one term");
    step(5'b10001, MODE_D, 1'b1, "R1 inverted");
    step(5'b00000, MODE_D, 1'b1, "R1 inverted zero");
    step(5'b11111, MODE_D, 1'b0, "R1 all terms");

    // R2 T mode
    step(5'b01000, MODE_T, 1'b0, "R2 toggle");
    step(5'b00000, MODE_T, 1'b0, "R2 hold");
    step(5'b00000, MODE_T, 1'b1, "R2 toggle inv");
    step(5'b00010, MODE_T, 1'b1, "R2 hold inv");
    step(5'b00010, MODE_T, 1'b0, "R2 toggle again");

    // R3 bypass
    mode_i = MODE_BYP; pt_i = 5'b00010; invert_i = 1'b0; #1;
    chk(q_o === 1'b1, "R3 bypass or", int'(q_o), 1);
    invert_i = 1'b1; #1;
    chk(q_o === 1'b0, "R3 bypass inv", int'(q_o), 0);
    mode_i = MODE_BY2; pt_i = 5'b00000; #1;
    chk(q_o === 1'b1, "R3 bypass code3", int'(q_o), 1);
    @(negedge clk);

    // R5 async clear by product term
    step(5'b00001, MODE_D, 1'b0, "R1 set up");
    rst_sel_i = SRC_PT; rst_pt_i = 1'b1; #1;
    chk(q_o === 1'b0, "R5 clear pt", int'(q_o), 0);
    rst_pt_i = 1'b0; model_q = 1'b0;
    @(negedge clk);
    step(5'b00001, MODE_D, 1'b0, "R1 set up");
    rst_sel_i = SRC_OFF; rst_pt_i = 1'b1; #1;
    chk(q_o === 1'b1, "R5 clear off", int'(q_o), 1);
    rst_pt_i = 1'b0;
    @(negedge clk);

    // R6 preset by product term
    step(5'b00000, MODE_D, 1'b0, "R1 set up");
    set_sel_i = SRC_PT; set_pt_i = 1'b1; #1;
    chk(q_o === 1'b1, "R6 preset pt", int'(q_o), 1);
    // R7 both active
    rst_sel_i = SRC_PT; rst_pt_i = 1'b1; #1;
    chk(q_o === 1'b0, "R7 clear wins", int'(q_o), 0);
    set_pt_i = 1'b0; #1;
    rst_pt_i = 1'b0; model_q = 1'b0;
    set_sel_i = SRC_OFF;
    @(negedge clk);

    // R5/R8 global reset pin
    step(5'b00001, MODE_D, 1'b0, "R1 set up");
    rst_sel_i = SRC_GLB; grst_ni = 1'b0; #1;
    chk(q_o === 1'b0, "R5 clear global", int'(q_o), 0);
    @(negedge clk);
    chk(tick_o === 1'b0, "R8 global restarts divider", int'(tick_o), 0);
    grst_ni = 1'b1; model_q = 1'b0;
    count_to_tick(n);
    chk(n == 31, "R8 tick after global", n, 31);
    repeat (2) @(negedge clk);

    // R6 preset from global pin
    rst_sel_i = SRC_OFF; set_sel_i = SRC_GLB; grst_ni = 1'b0; #1;
    chk(q_o === 1'b1, "R6 preset global", int'(q_o), 1);
    grst_ni = 1'b1; set_sel_i = SRC_OFF; model_q = 1'b1;
    @(negedge clk);
    step(5'b00000, MODE_D, 1'b0, "R1 after preset");

    // R9 capture stages
    dig_i = 4'h5; cmp_i = 4'hA; #1;
    chk(dig_o === 4'h0, "R9 dig before edge", int'(dig_o), 0);
    @(negedge clk);
    chk(dig_o === 4'h5, "R9 dig after edge", int'(dig_o), 5);
    chk(cmp_o === 4'h0, "R9 cmp hold", int'(cmp_o), 0);
    while (!tick_o) @(negedge clk);
    chk(cmp_o === 4'h0, "R9 cmp hold to tick", int'(cmp_o), 0);
    @(negedge clk);
    chk(cmp_o === 4'hA, "R9 cmp on tick", int'(cmp_o), 10);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule